// File: doc/BRIEF.md
# Detector-to-Memory Path Reconfiguration Controller

This block decides how the detector lines of an imaging front end reach storage. Every detector line must pass through a compressor, and every compressor in use must be tied to a memory bank. Two parameter matrices describe which detector-to-compressor and compressor-to-bank wires exist. The controller stores one compressor choice per detector and one bank choice per compressor. From these choices, together with the per-compressor fault inputs and the per-bank availability inputs, it derives whether each compressor and each detector can write, and a global running flag.

When a fault or availability change leaves a detector without a working path, the controller plans a new set of connections. It does this with a multi-cycle greedy search and then applies the whole plan in one commit cycle as a set of connection commands. While the system is healthy, it issues no commands at all. If some detector cannot be served, that detector stays unconnected and a flag reports the failure. The flag holds until the next plan is committed.

Top module: `path_realloc_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it, every stored assignment is 0, running is 0, the new-configuration output is 1, and the done pulse and the unroutable flag are 0.
- R2: A detector assignment value k in 1..N_CMP means compressor k-1 (0-based), and a compressor assignment value k in 1..N_BANK means bank k-1. The value 0 means not connected. Internal commands use all-ones for keep, 0 for disconnect and k for connect, and a non-keep command replaces the stored value at the next clock edge.
- R3: A compressor can write exactly when its registered fault bit is clear and it holds a nonzero bank whose registered availability bit is 1.
- R4: A detector can write exactly when its compressor can write. Running is the AND of all detector writing bits.
- R5: If running was 1 in the previous cycle, no command is issued. A fault or availability change that leaves the system running causes no search and no change to any assignment.
- R6: No two detectors hold the same nonzero compressor, and no two compressors hold the same nonzero bank.
- R7: A connect command only follows a link present in the matrices, and only toward a compressor whose fault bit is clear or a bank whose availability bit is 1.
- R8: On a commit, a faulty compressor that holds a bank is commanded to disconnect. A compressor that no detector uses holds bank 0.
- R9: A compressor fault is permanent once seen, even when the input drops. The new-configuration output pulses for one cycle, one cycle after any registered fault or availability bit changes, and at no other time.
- R10: The plan serves detectors in ascending index. For each detector it takes the lowest-index linked, healthy, not-yet-planned compressor that still has a linked, available, not-yet-planned bank, and it uses the lowest such bank.
- R11: A detector with no legal path is left at 0 and the unroutable output goes to 1 on that commit. The output keeps its value until the next commit.
- R12: The done output pulses for exactly one cycle after a commit, in the cycle the new assignments first appear. A search whose inputs changed while it ran is discarded and repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_fault_i | input | N_CMP | Fault indication per compressor |
| bank_avail_i | input | N_BANK | Availability per memory bank |
| det_asg_o | output | N_DET*CW | Compressor assignment per detector, detector d at bits [d*CW +: CW] |
| cmp_asg_o | output | N_CMP*BW | Bank assignment per compressor, compressor c at bits [c*BW +: BW] |
| det_writing_o | output | N_DET | Per-detector write capability |
| cmp_writing_o | output | N_CMP | Per-compressor write capability |
| running_o | output | 1 | All detectors can write |
| new_cfg_o | output | 1 | Fault or availability state just changed |
| realloc_done_o | output | 1 | One-cycle pulse after a plan is committed |
| unroutable_o | output | 1 | Last committed plan left a detector unconnected |

## Verification
The assertions on command legality assume that the fault and availability inputs only ever change in ways the controller sees through its new-configuration pulse. A change that lands during a search aborts that search, so a committed plan always matches the registered health state. The bench changes one input at a time, from the clock edge, and waits for the done pulse or for a fixed quiet window before it changes anything else. In this way no input change falls inside a commit cycle that the checks depend on.

// File: rtl/pathctl_pkg.sv
package pathctl_pkg;
  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_SCAN   = 2'd1,
    S_COMMIT = 2'd2
  } srch_st_e;
endpackage

// File: rtl/pathctl_health.sv
module pathctl_health #(
  parameter int N_CMP  = 4,
  parameter int N_BANK = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CMP-1:0]  cmp_fault_i,
  input  logic [N_BANK-1:0] bank_avail_i,
  output logic [N_CMP-1:0]  fault_q,
  output logic [N_BANK-1:0] avail_q,
  output logic              new_cfg_q
);
  logic [N_CMP-1:0] fault_nx;

  assign fault_nx = fault_q | cmp_fault_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q   <= '0;
      avail_q   <= '1;
      new_cfg_q <= 1'b1;
    end else begin
      fault_q   <= fault_nx;
      avail_q   <= bank_avail_i;
      new_cfg_q <= (fault_nx != fault_q) || (bank_avail_i != avail_q);
    end
  end

  // R9
  fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ((fault_q & $past(fault_q)) == $past(fault_q)));

  // R9
  new_cfg_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && new_cfg_q) |-> ((fault_q != $past(fault_q)) || (avail_q != $past(avail_q))));
endmodule

// File: rtl/pathctl_store.sv
module pathctl_store #(
  parameter int N_DET  = 3,
  parameter int N_CMP  = 4,
  parameter int N_BANK = 8,
  parameter int CW     = 3,
  parameter int BW     = 4,
  parameter logic [N_DET*N_CMP-1:0]  DC_LINKS = '1,
  parameter logic [N_CMP*N_BANK-1:0] CB_LINKS = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW:0]       det_cmd_i [N_DET],
  input  logic [BW:0]       cmp_cmd_i [N_CMP],
  input  logic [N_CMP-1:0]  fault_q,
  input  logic [N_BANK-1:0] avail_q,
  output logic [CW-1:0]     det_asg_q [N_DET],
  output logic [BW-1:0]     cmp_asg_q [N_CMP],
  output logic [N_CMP-1:0]  cmp_wr_o,
  output logic [N_DET-1:0]  det_wr_o,
  output logic              running_o
);
  localparam logic [CW:0] DKEEP = {(CW+1){1'b1}};
  localparam logic [BW:0] BKEEP = {(BW+1){1'b1}};

  logic [N_CMP-1:0] cmp_taken;
  logic             cmd_any;

  for (genvar d = 0; d < N_DET; d++) begin : g_det
    always_ff @(posedge clk) begin
      if (rst) det_asg_q[d] <= '0;
      else if (det_cmd_i[d] != DKEEP) det_asg_q[d] <= det_cmd_i[d][CW-1:0];
    end
  end

  for (genvar c = 0; c < N_CMP; c++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (rst) cmp_asg_q[c] <= '0;
      else if (cmp_cmd_i[c] != BKEEP) cmp_asg_q[c] <= cmp_cmd_i[c][BW-1:0];
    end
  end

  always_comb begin
    cmp_wr_o = '0;
    for (int c = 0; c < N_CMP; c++)
      for (int b = 0; b < N_BANK; b++)
        if (!fault_q[c] && avail_q[b] && cmp_asg_q[c] == BW'(b + 1)) cmp_wr_o[c] = 1'b1;
  end

  always_comb begin
    det_wr_o  = '0;
    cmp_taken = '0;
    for (int d = 0; d < N_DET; d++)
      for (int c = 0; c < N_CMP; c++)
        if (det_asg_q[d] == CW'(c + 1)) begin
          cmp_taken[c] = 1'b1;
          if (cmp_wr_o[c]) det_wr_o[d] = 1'b1;
        end
  end

  assign running_o = &det_wr_o;

  always_comb begin
    cmd_any = 1'b0;
    for (int d = 0; d < N_DET; d++) if (det_cmd_i[d] != DKEEP) cmd_any = 1'b1;
    for (int c = 0; c < N_CMP; c++) if (cmp_cmd_i[c] != BKEEP) cmd_any = 1'b1;
  end

  for (genvar i = 0; i < N_DET; i++) begin : g_dx
    for (genvar j = i + 1; j < N_DET; j++) begin : g_dy
      // R6
      det_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(det_asg_q[i] != '0 && det_asg_q[i] == det_asg_q[j]));
    end
    for (genvar c = 0; c < N_CMP; c++) begin : g_dl
      // R7
      det_link_chk: assert property (@(posedge clk) disable iff (rst)
        (det_cmd_i[i] == (CW+1)'(c + 1)) |-> (DC_LINKS[i*N_CMP + c] && !fault_q[c]));
    end
  end

  for (genvar i = 0; i < N_CMP; i++) begin : g_cx
    for (genvar j = i + 1; j < N_CMP; j++) begin : g_cy
      // R6
      cmp_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cmp_asg_q[i] != '0 && cmp_asg_q[i] == cmp_asg_q[j]));
    end
    for (genvar b = 0; b < N_BANK; b++) begin : g_cl
      // R7
      cmp_link_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_cmd_i[i] == (BW+1)'(b + 1)) |-> (CB_LINKS[i*N_BANK + b] && avail_q[b]));
    end
    // R8
    faulty_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd_any && fault_q[i] && cmp_asg_q[i] != '0) |-> (cmp_cmd_i[i] == '0));
    // R8
    unused_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !cmp_taken[i] |-> (cmp_asg_q[i] == '0));
  end
endmodule

// File: rtl/pathctl_search.sv
module pathctl_search
  import pathctl_pkg::*;
#(
  parameter int N_DET  = 3,
  parameter int N_CMP  = 4,
  parameter int N_BANK = 8,
  parameter int CW     = 3,
  parameter int BW     = 4,
  parameter logic [N_DET*N_CMP-1:0]  DC_LINKS = '1,
  parameter logic [N_CMP*N_BANK-1:0] CB_LINKS = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CMP-1:0]  fault_q,
  input  logic [N_BANK-1:0] avail_q,
  input  logic              new_cfg_i,
  input  logic              running_i,
  input  logic [CW-1:0]     det_asg_i [N_DET],
  input  logic [BW-1:0]     cmp_asg_i [N_CMP],
  output logic [CW:0]       det_cmd_o [N_DET],
  output logic [BW:0]       cmp_cmd_o [N_CMP],
  output logic              done_q,
  output logic              unrt_q
);
  localparam int DW  = (N_DET  > 1) ? $clog2(N_DET)  : 1;
  localparam int CKW = (N_CMP  > 1) ? $clog2(N_CMP)  : 1;
  localparam int BKW = (N_BANK > 1) ? $clog2(N_BANK) : 1;
  localparam logic [CW:0] DKEEP = {(CW+1){1'b1}};
  localparam logic [BW:0] BKEEP = {(BW+1){1'b1}};

  srch_st_e          st_q;
  logic [DW-1:0]     d_q;
  logic [CKW-1:0]    c_q;
  logic [CW-1:0]     plan_det [N_DET];
  logic [BW-1:0]     plan_cmp [N_CMP];
  logic [N_CMP-1:0]  cmp_used;
  logic [N_BANK-1:0] bank_used;
  logic              miss_q, pend_q, run_prev_q;

  logic              link_ok, found, commit_ok, start, last_det, last_cmp;
  logic [N_BANK-1:0] cb_row;
  logic [BKW-1:0]    pick;

  always_comb begin
    link_ok = 1'b0;
    cb_row  = '0;
    for (int dd = 0; dd < N_DET; dd++)
      for (int cc = 0; cc < N_CMP; cc++)
        if (d_q == DW'(dd) && c_q == CKW'(cc)) link_ok = DC_LINKS[dd*N_CMP + cc];
    for (int cc = 0; cc < N_CMP; cc++)
      if (c_q == CKW'(cc)) cb_row = CB_LINKS[cc*N_BANK +: N_BANK];
  end

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int b = N_BANK - 1; b >= 0; b--)
      if (cb_row[b] && avail_q[b] && !bank_used[b]) begin
        found = 1'b1;
        pick  = BKW'(b);
      end
  end

  assign last_det  = (d_q == DW'(N_DET - 1));
  assign last_cmp  = (c_q == CKW'(N_CMP - 1));
  assign start     = (st_q == S_IDLE) && (pend_q || new_cfg_i) && !running_i;
  assign commit_ok = (st_q == S_COMMIT) && !running_i && !run_prev_q && !pend_q && !new_cfg_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_IDLE;
      d_q        <= '0;
      c_q        <= '0;
      cmp_used   <= '0;
      bank_used  <= '0;
      miss_q     <= 1'b0;
      pend_q     <= 1'b0;
      run_prev_q <= 1'b0;
      done_q     <= 1'b0;
      unrt_q     <= 1'b0;
      for (int d = 0; d < N_DET; d++) plan_det[d] <= '0;
      for (int c = 0; c < N_CMP; c++) plan_cmp[c] <= '0;
    end else begin
      run_prev_q <= running_i;
      done_q     <= commit_ok;
      if (commit_ok) unrt_q <= miss_q;
      if (st_q == S_IDLE) pend_q <= 1'b0;
      else if (st_q == S_COMMIT && !commit_ok) pend_q <= 1'b1;
      else pend_q <= pend_q | new_cfg_i;
      case (st_q)
        S_IDLE: if (start) begin
          st_q      <= S_SCAN;
          d_q       <= '0;
          c_q       <= '0;
          cmp_used  <= '0;
          bank_used <= '0;
          miss_q    <= 1'b0;
          for (int d = 0; d < N_DET; d++) plan_det[d] <= '0;
          for (int c = 0; c < N_CMP; c++) plan_cmp[c] <= '0;
        end
        S_SCAN: begin
          if (link_ok && !fault_q[c_q] && !cmp_used[c_q] && found) begin
            plan_det[d_q]   <= CW'(c_q) + CW'(1);
            plan_cmp[c_q]   <= BW'(pick) + BW'(1);
            cmp_used[c_q]   <= 1'b1;
            bank_used[pick] <= 1'b1;
          end else if (last_cmp) begin
            miss_q <= 1'b1;
          end
          if ((link_ok && !fault_q[c_q] && !cmp_used[c_q] && found) || last_cmp) begin
            c_q <= '0;
            if (last_det) st_q <= S_COMMIT;
            else d_q <= d_q + DW'(1);
          end else begin
            c_q <= c_q + CKW'(1);
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    for (int d = 0; d < N_DET; d++)
      det_cmd_o[d] = (commit_ok && plan_det[d] != det_asg_i[d]) ? {1'b0, plan_det[d]} : DKEEP;
    for (int c = 0; c < N_CMP; c++)
      cmp_cmd_o[c] = (commit_ok && plan_cmp[c] != cmp_asg_i[c]) ? {1'b0, plan_cmp[c]} : BKEEP;
  end

  // R5
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    $past(running_i) |-> !commit_ok);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R12
  done_src_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(st_q == S_COMMIT));
endmodule

// File: rtl/path_realloc_ctrl.sv
module path_realloc_ctrl #(
  parameter int N_DET  = 3,
  parameter int N_CMP  = 4,
  parameter int N_BANK = 8,
  parameter logic [N_DET*N_CMP-1:0]  DC_LINKS = 12'hC63,
  parameter logic [N_CMP*N_BANK-1:0] CB_LINKS = 32'hE018_0603,
  parameter int CW = $clog2(N_CMP + 1),
  parameter int BW = $clog2(N_BANK + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_CMP-1:0]    cmp_fault_i,
  input  logic [N_BANK-1:0]   bank_avail_i,
  output logic [N_DET*CW-1:0] det_asg_o,
  output logic [N_CMP*BW-1:0] cmp_asg_o,
  output logic [N_DET-1:0]    det_writing_o,
  output logic [N_CMP-1:0]    cmp_writing_o,
  output logic                running_o,
  output logic                new_cfg_o,
  output logic                realloc_done_o,
  output logic                unroutable_o
);
  logic [N_CMP-1:0]  fault_q;
  logic [N_BANK-1:0] avail_q;
  logic              new_cfg_q, running;
  logic [CW:0]       det_cmd [N_DET];
  logic [BW:0]       cmp_cmd [N_CMP];
  logic [CW-1:0]     det_asg [N_DET];
  logic [BW-1:0]     cmp_asg [N_CMP];

  pathctl_health #(.N_CMP(N_CMP), .N_BANK(N_BANK)) u_health (
    .clk(clk), .rst(rst), .cmp_fault_i(cmp_fault_i), .bank_avail_i(bank_avail_i),
    .fault_q(fault_q), .avail_q(avail_q), .new_cfg_q(new_cfg_q)
  );

  pathctl_store #(.N_DET(N_DET), .N_CMP(N_CMP), .N_BANK(N_BANK), .CW(CW), .BW(BW),
                  .DC_LINKS(DC_LINKS), .CB_LINKS(CB_LINKS)) u_store (
    .clk(clk), .rst(rst), .det_cmd_i(det_cmd), .cmp_cmd_i(cmp_cmd),
    .fault_q(fault_q), .avail_q(avail_q), .det_asg_q(det_asg), .cmp_asg_q(cmp_asg),
    .cmp_wr_o(cmp_writing_o), .det_wr_o(det_writing_o), .running_o(running)
  );

  pathctl_search #(.N_DET(N_DET), .N_CMP(N_CMP), .N_BANK(N_BANK), .CW(CW), .BW(BW),
                   .DC_LINKS(DC_LINKS), .CB_LINKS(CB_LINKS)) u_search (
    .clk(clk), .rst(rst), .fault_q(fault_q), .avail_q(avail_q), .new_cfg_i(new_cfg_q),
    .running_i(running), .det_asg_i(det_asg), .cmp_asg_i(cmp_asg),
    .det_cmd_o(det_cmd), .cmp_cmd_o(cmp_cmd), .done_q(realloc_done_o), .unrt_q(unroutable_o)
  );

  for (genvar d = 0; d < N_DET; d++) begin : g_do
    assign det_asg_o[d*CW +: CW] = det_asg[d];
  end
  for (genvar c = 0; c < N_CMP; c++) begin : g_co
    assign cmp_asg_o[c*BW +: BW] = cmp_asg[c];
  end

  assign running_o = running;
  assign new_cfg_o = new_cfg_q;
endmodule

// File: tb/sim_path_realloc_ctrl.sv
module sim_path_realloc_ctrl;
  localparam int CW = 3;
  localparam int BW = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  fault = '0;
  logic [7:0]  avail = '1;
  logic [8:0]  det_asg;
  logic [15:0] cmp_asg;
  logic [2:0]  det_wr;
  logic [3:0]  cmp_wr;
  logic        running, new_cfg, done, unrt;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  path_realloc_ctrl u0 (
    .clk(clk), .rst(rst), .cmp_fault_i(fault), .bank_avail_i(avail),
    .det_asg_o(det_asg), .cmp_asg_o(cmp_asg), .det_writing_o(det_wr),
    .cmp_writing_o(cmp_wr), .running_o(running), .new_cfg_o(new_cfg),
    .realloc_done_o(done), .unroutable_o(unrt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dg(input int d); return int'(det_asg[d*CW +: CW]); endfunction
  function automatic int cg(input int c); return int'(cmp_asg[c*BW +: BW]); endfunction

  task automatic expect_map(input string req, input int d0, input int d1, input int d2,
                            input int c0, input int c1, input int c2, input int c3);
    chk(dg(0) == d0, req, dg(0), d0);
    chk(dg(1) == d1, req, dg(1), d1);
    chk(dg(2) == d2, req, dg(2), d2);
    chk(cg(0) == c0, req, cg(0), c0);
    chk(cg(1) == c1, req, cg(1), c1);
    chk(cg(2) == c2, req, cg(2), c2);
    chk(cg(3) == c3, req, cg(3), c3);
  endtask

  task automatic wait_done(input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 100 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk(seen, req, int'(seen), 1);
    @(negedge clk);
    chk(!done, "R12 done one cycle", int'(done), 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(det_asg == '0 && cmp_asg == '0, "R1 assignments", int'(cmp_asg), 0);
    chk(running == 1'b0, "R1 running", int'(running), 0);
    chk(new_cfg == 1'b1, "R1 new_cfg", int'(new_cfg), 1);
    chk(!done && !unrt, "R1 done/unroutable", int'({done, unrt}), 0);
    @(posedge clk); #1 rst = 1'b0;
  endtask

  task automatic t_initial();
    wait_done("R12 initial plan done");
    // R10 greedy order, R2 one-based encoding
    expect_map("R10 initial plan", 1, 2, 3, 1, 2, 4, 0);
    // R3 R4 writing and running
    chk(cmp_wr == 4'b0111, "R3 compressor writing", int'(cmp_wr), 7);
    chk(det_wr == 3'b111 && running, "R4 running", int'({det_wr, running}), 15);
    chk(!unrt, "R11 routable", int'(unrt), 0);
  endtask

  task automatic t_freeze();
    int dones = 0;
    @(posedge clk); #1 avail[7] = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(new_cfg, "R9 new_cfg on bank change", int'(new_cfg), 1);
    @(negedge clk);
    chk(!new_cfg, "R9 new_cfg single pulse", int'(new_cfg), 0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (done) dones++;
    end
    // R5 frozen while running
    chk(dones == 0, "R5 no search while running", dones, 0);
    expect_map("R5 assignments unchanged", 1, 2, 3, 1, 2, 4, 0);
    @(posedge clk); #1 avail[7] = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_fault_c1();
    @(posedge clk); #1 fault[1] = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(!cmp_wr[1], "R3 faulty compressor not writing", int'(cmp_wr[1]), 0);
    chk(!running, "R4 running drops", int'(running), 0);
    wait_done("R12 replan after fault");
    // R8 faulty compressor released, R10 next free choice
    expect_map("R8 fault c1 plan", 1, 3, 4, 1, 0, 4, 6);
    chk(running, "R4 running restored", int'(running), 1);
  endtask

  task automatic t_fault_release();
    int pulses = 0;
    @(posedge clk); #1 fault[1] = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (new_cfg || done) pulses++;
    end
    // R9 fault stays latched
    chk(pulses == 0, "R9 fault sticky", pulses, 0);
    expect_map("R9 assignments after release", 1, 3, 4, 1, 0, 4, 6);
  endtask

  task automatic t_bank0();
    @(posedge clk); #1 avail[0] = 1'b0;
    wait_done("R12 replan after bank loss");
    // R7 only available linked bank, R10 lowest
    expect_map("R7 bank0 plan", 1, 3, 4, 2, 0, 4, 6);
    chk(running && cmp_wr == 4'b1101, "R3 writing after bank move", int'(cmp_wr), 13);
  endtask

  task automatic t_unroutable();
    @(posedge clk); #1 fault[3] = 1'b1;
    wait_done("R12 replan after second fault");
    // R11 detector 2 left unconnected
    expect_map("R11 unroutable plan", 1, 3, 0, 2, 0, 4, 0);
    chk(unrt, "R11 flag set", int'(unrt), 1);
    chk(!running && det_wr == 3'b011, "R4 partial writing", int'(det_wr), 3);
    repeat (10) @(negedge clk);
    chk(unrt && !done, "R11 flag held", int'({unrt, done}), 2);
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_initial();
    t_freeze();
    t_fault_c1();
    t_fault_release();
    t_bank0();
    t_unroutable();
    fault = '0;
    avail = '1;
    t_reset();
    t_initial();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule